// File: doc/BRIEF.md
# Serial Register Control Port

This block is a serial slave that lets an external host read and write a small byte-wide register file inside the chip. The host holds a low-active select line down for the whole exchange. It first shifts in a 16-bit command word, then exchanges one or more data bytes. The serial clock, select and data inputs are synchronous to the system clock and are sampled by it. A serial-clock rising edge captures an input bit. A serial-clock falling edge launches the next read bit.

The command word sets the direction, the length and the start address. The length can be fixed at one to three bytes, or the transfer can run open-ended for as long as select stays low. After each byte the address moves one step. The direction of that step depends on the bit order. Both the bit order and the pin that carries read data are chosen by bits of the configuration register at address 0. The register file contents are also presented in parallel to the rest of the chip.

Top module: `sctl_port`

## Requirements
- R1: The command word has read/write in bit 15 (1 = read), a length code in bits [14:13] (00 = 1 byte, 01 = 2, 10 = 3, 11 = open-ended), and the start address in bits [12:0].
- R2: A fixed-length transfer stops after its byte count. Any further serial clocks are ignored until select goes high: no register changes and no read output is enabled.
- R3: Length code 11 keeps moving bytes for as long as the host keeps clocking with select low.
- R4: Raising select at any time returns the port to waiting for a command. A partly received byte is dropped and changes no register.
- R5: Configuration bit 1 picks the bit order. At 0, command bit 15 and data bit 7 travel first. At 1, command bit 0 and data bit 0 travel first.
- R6: A read shifts out the bytes from the addressed registers. Each bit is launched on a serial-clock falling edge and is valid at the following rising edge.
- R7: Configuration bit 0 picks the read pin. At 0, read data drives the shared data pin. At 1, it drives the separate output pin. The chosen pin's enable is high only during the read data phase, and the other enable stays low.
- R8: A write stores a byte in its register on the rising edge that carries the byte's eighth bit.
- R9: After each byte the address drops by one when the order is most-significant-first, and rises by one when it is least-significant-first. The address wraps within 13 bits.
- R10: Register 0 holds three writable bits [2:0], loaded from data bits [2:0]; data bits [7:3] are ignored. Bit 3 always reads 1. Bits 7, 6, 5 and 4 read back as copies of bits 0, 1, 2 and 3.
- R11: Addresses at or above REG_DEPTH ignore writes and read as 0x00.
- R12: After reset every register reads 0x00, except register 0, which reads 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial clock from the host |
| sdioIn | input | 1 | Serial data input (shared data pin, receive side) |
| sdioOut | output | 1 | Read data toward the shared data pin |
| sdioOe | output | 1 | Drive enable for the shared data pin |
| sdoOut | output | 1 | Read data toward the separate output pin |
| sdoOe | output | 1 | Drive enable for the separate output pin |
| regsFlat | output | REG_DEPTH*8 | Register file contents, byte i at bits [8i+7:8i] |

## Verification
The bench builds the port with REG_DEPTH = 32, which is far smaller than the 13-bit address space. This makes both cases reachable in short transfers: writes and reads above the implemented range, and a descending read that wraps from register 0 to the top address. Thirty-two registers also leave room for open-ended runs and mid-byte aborts that do not overlap the configuration register. The bench flips the configuration register between both bit orders and both read pins partway through the run.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  // Command word layout is fixed by the serial format.
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_INSTR = 2'd0,
    ST_DATA  = 2'd1,
    ST_HOLD  = 2'd2
  } sctlState_e;

  // Strobes from control to datapath, valid for one system clock.
  typedef struct packed {
    logic              shiftIn;
    logic              commitWr;
    logic              loadTx;
    logic              driveOut;
    logic [BIT_W-1:0]  bitIdx;
    logic [ADDR_W-1:0] addr;
  } sctlStrobe_t;
endpackage

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              sclk,
  input  logic [CMD_W-1:0]  shNext,
  input  logic              lsbFirst,
  input  logic              sdoMode,
  output sctlStrobe_t       stb,
  output logic              sdioOe,
  output logic              sdoOe
);
  localparam int CNT_W = $clog2(CMD_W);

  sctlState_e        state;
  logic              sclkQ;
  logic [CNT_W-1:0]  instrCnt;
  logic [BIT_W-1:0]  dataCnt;
  logic [1:0]        byteCnt;
  logic [1:0]        lenQ;
  logic              rnwQ;
  logic              streamQ;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] stepAddr;
  logic              rise, fall;
  logic              instrLast, byteLast, lastByte, readPh;

  assign rise      = sclk & ~sclkQ & ~csN;
  assign fall      = ~sclk & sclkQ & ~csN;
  assign instrLast = (state == ST_INSTR) && rise && (instrCnt == CNT_W'(CMD_W - 1));
  assign byteLast  = (state == ST_DATA) && rise && (dataCnt == BIT_W'(BYTE_W - 1));
  assign lastByte  = !streamQ && (byteCnt == lenQ);
  assign stepAddr  = lsbFirst ? curAddr + ADDR_W'(1) : curAddr - ADDR_W'(1);

  always_comb begin
    stb          = '0;
    stb.shiftIn  = rise && (state != ST_HOLD);
    stb.commitWr = byteLast && !rnwQ;
    stb.loadTx   = (instrLast && shNext[CMD_W-1]) || (byteLast && rnwQ && !lastByte);
    stb.driveOut = fall && (state == ST_DATA) && rnwQ;
    stb.bitIdx   = lsbFirst ? dataCnt : ~dataCnt;
    if (stb.commitWr)   stb.addr = curAddr;
    else if (instrLast) stb.addr = shNext[ADDR_W-1:0];
    else                stb.addr = stepAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkQ    <= 1'b0;
      state    <= ST_INSTR;
      instrCnt <= '0;
      dataCnt  <= '0;
      byteCnt  <= '0;
      lenQ     <= '0;
      rnwQ     <= 1'b0;
      streamQ  <= 1'b0;
      curAddr  <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        state    <= ST_INSTR;
        instrCnt <= '0;
        dataCnt  <= '0;
        byteCnt  <= '0;
      end else if (rise) begin
        unique case (state)
          ST_INSTR: begin
            instrCnt <= instrCnt + CNT_W'(1);
            if (instrLast) begin
              state   <= ST_DATA;
              rnwQ    <= shNext[CMD_W-1];
              lenQ    <= shNext[CMD_W-2:CMD_W-3];
              streamQ <= &shNext[CMD_W-2:CMD_W-3];
              curAddr <= shNext[ADDR_W-1:0];
              dataCnt <= '0;
              byteCnt <= '0;
            end
          end
          ST_DATA: begin
            dataCnt <= dataCnt + BIT_W'(1);
            if (byteLast) begin
              curAddr <= stepAddr;
              if (lastByte) state <= ST_HOLD;
              else          byteCnt <= byteCnt + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign readPh = (state == ST_DATA) && rnwQ && !csN;
  assign sdioOe = readPh && !sdoMode;
  assign sdoOe  = readPh && sdoMode;

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdioOe && sdoOe)); // R7

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    csN |=> (state == ST_INSTR && instrCnt == '0)); // R4

  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !streamQ) |-> (byteCnt <= lenQ)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byteLast |=> (curAddr == ($past(lsbFirst) ? $past(curAddr) + ADDR_W'(1)
                                              : $past(curAddr) - ADDR_W'(1)))); // R9
endmodule

// File: rtl/sctl_dpath.sv
module sctl_dpath
  import sctl_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sctlStrobe_t           stb,
  input  logic                  sdIn,
  output logic [CMD_W-1:0]      shNext,
  output logic                  lsbFirst,
  output logic                  sdoMode,
  output logic                  serOut,
  output logic [DEPTH*BYTE_W-1:0] regsFlat
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [2:0]        cfgLow;
  logic [BYTE_W-1:0] cfgView;
  logic [BYTE_W-1:0] memQ [1:DEPTH-1];
  logic [BYTE_W-1:0] view [DEPTH];
  logic [CMD_W-1:0]  shReg;
  logic [BYTE_W-1:0] txByte, wrByte, rdByte;
  logic              serQ;
  logic              inRange;
  logic [IDX_W-1:0]  idx;

  assign lsbFirst = cfgLow[1];
  assign sdoMode  = cfgLow[0];

  // One shifter serves both orders: left for MSB-first, right for LSB-first.
  assign shNext  = lsbFirst ? {sdIn, shReg[CMD_W-1:1]} : {shReg[CMD_W-2:0], sdIn};
  assign wrByte  = lsbFirst ? shNext[CMD_W-1:CMD_W-BYTE_W] : shNext[BYTE_W-1:0];

  assign cfgView = {cfgLow[0], cfgLow[1], cfgLow[2], 1'b1, 1'b1, cfgLow};
  assign inRange = int'(stb.addr) < DEPTH;
  assign idx     = stb.addr[IDX_W-1:0];

  always_comb begin
    view[0] = cfgView;
    for (int i = 1; i < DEPTH; i++) view[i] = memQ[i];
  end

  assign rdByte = inRange ? view[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg  <= '0;
      txByte <= '0;
      serQ   <= 1'b0;
      cfgLow <= '0;
      for (int i = 1; i < DEPTH; i++) memQ[i] <= '0;
    end else begin
      if (stb.shiftIn)  shReg  <= shNext;
      if (stb.loadTx)   txByte <= rdByte;
      if (stb.driveOut) serQ   <= txByte[stb.bitIdx];
      if (stb.commitWr && inRange) begin
        if (idx == '0) cfgLow <= wrByte[2:0];
        for (int i = 1; i < DEPTH; i++)
          if (idx == IDX_W'(i)) memQ[i] <= wrByte;
      end
    end
  end

  assign serOut = serQ;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign regsFlat[g*BYTE_W +: BYTE_W] = view[g];
  end

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.driveOut |=> $stable(serQ)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.commitWr |=> $stable(cfgLow)); // R10
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int REG_DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      sdioIn,
  output logic                      sdioOut,
  output logic                      sdioOe,
  output logic                      sdoOut,
  output logic                      sdoOe,
  output logic [REG_DEPTH*8-1:0]    regsFlat
);
  sctlStrobe_t      stb;
  logic [CMD_W-1:0] shNext;
  logic             lsbFirst, sdoMode, serOut;

  sctl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .csN      (csN),
    .sclk     (sclk),
    .shNext   (shNext),
    .lsbFirst (lsbFirst),
    .sdoMode  (sdoMode),
    .stb      (stb),
    .sdioOe   (sdioOe),
    .sdoOe    (sdoOe)
  );

  sctl_dpath #(.DEPTH(REG_DEPTH)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .sdIn     (sdioIn),
    .shNext   (shNext),
    .lsbFirst (lsbFirst),
    .sdoMode  (sdoMode),
    .serOut   (serOut),
    .regsFlat (regsFlat)
  );

  assign sdioOut = serOut;
  assign sdoOut  = serOut;
endmodule

// File: tb/sim_sctl_port.sv
module sim_sctl_port;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0, csN = 1'b1, sclk = 1'b0, sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [DEPTH*8-1:0] regsFlat;
  logic [DEPTH*8-1:0] expVec;

  int total = 0, bad = 0, cyc = 0;
  bit chkOn = 1'b0, expRdPh = 1'b0;
  logic [2:0] expCfg = 3'b000;
  logic [7:0] expMem [DEPTH];
  logic [7:0] wrBuf [8];

  sctl_port #(.REG_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .regsFlat(regsFlat)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] expView(int i);
    if (i == 0) return {expCfg[0], expCfg[1], expCfg[2], 1'b1, 1'b1, expCfg};
    return expMem[i];
  endfunction

  function automatic logic [7:0] expRd(int a);
    if (a >= DEPTH) return 8'h00;
    return expView(a);
  endfunction

  task automatic expWrite(int a, logic [7:0] d);
    if (a == 0) expCfg = d[2:0];
    else if (a < DEPTH) expMem[a] = d;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // Reference compare on every clock, after the design's edge has settled.
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      $display("FAIL watchdog R4 act=running exp=finished");
      summary();
      $finish;
    end
    #1;
    if (chkOn) begin
      for (int i = 0; i < DEPTH; i++) expVec[i*8 +: 8] = expView(i);
      total++;
      if (regsFlat !== expVec) begin
        bad++;
        $display("FAIL R8/R10/R11 regs act=%h exp=%h", regsFlat, expVec);
      end
      chk("R7", "sdioOe", {31'b0, sdioOe}, {31'b0, expRdPh & ~expCfg[0]});
      chk("R7", "sdoOe",  {31'b0, sdoOe},  {31'b0, expRdPh &  expCfg[0]});
    end
  end

  task automatic xfer(input bit rnw, input int code, input int addr, input int nb,
                      input int extra, input int cutBits, input string req);
    logic [15:0] iw;
    logic [7:0]  rb;
    int a, sent, bi;
    bit lsb, live;
    iw   = {rnw, code[1:0], addr[12:0]};
    sent = 0;
    @(negedge clk); csN = 1'b0;
    lsb = expCfg[1];
    for (int k = 0; k < 16; k++) begin
      if (cutBits >= 0 && sent == cutBits) break;
      @(negedge clk);
      sdioIn = lsb ? iw[k] : iw[15-k];
      sclk   = 1'b1;
      if (k == 15 && rnw) expRdPh = 1'b1;
      sent++;
      @(negedge clk); sclk = 1'b0;
    end
    a = addr;
    if (sent == 16) begin
      for (int j = 0; j < nb + extra; j++) begin
        live = (j < nb);
        lsb  = expCfg[1];
        rb   = expRd(a);
        for (int k = 0; k < 8; k++) begin
          if (cutBits >= 0 && sent == cutBits) break;
          bi = lsb ? k : 7 - k;
          @(negedge clk);
          if (rnw && live)
            chk(req, $sformatf("read a=%0h bit%0d", a, bi),
                {31'b0, (expCfg[0] ? sdoOut : sdioOut)}, {31'b0, rb[bi]});
          sdioIn = rnw ? 1'b0 : wrBuf[j][bi];
          sclk   = 1'b1;
          if (k == 7 && live) begin
            if (!rnw) expWrite(a, wrBuf[j]);
            a = lsb ? (a + 1) % 8192 : (a + 8191) % 8192;
            if (j == nb - 1 && code != 3) expRdPh = 1'b0;
          end
          sent++;
          @(negedge clk); sclk = 1'b0;
        end
        if (cutBits >= 0 && sent == cutBits) break;
      end
    end
    @(negedge clk); csN = 1'b1; expRdPh = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkOn = 1'b1;

    // R12: reset contents
    chk("R12", "cfg after reset", {24'b0, regsFlat[7:0]}, 32'h18);
    chk("R12", "reg1 after reset", {24'b0, regsFlat[15:8]}, 32'h00);

    // R1 / R8: single-byte write then read, MSB-first
    wrBuf[0] = 8'hA5;
    xfer(1'b0, 0, 5, 1, 0, -1, "R8");
    chk("R1", "reg5 written", {24'b0, regsFlat[5*8 +: 8]}, 32'hA5);
    xfer(1'b1, 0, 5, 1, 0, -1, "R6");

    // R9 descending addresses, R2 extra bytes ignored
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33;
    wrBuf[3] = 8'hEE; wrBuf[4] = 8'hFF;
    xfer(1'b0, 2, 10, 3, 2, -1, "R1");
    chk("R9", "reg9 second byte", {24'b0, regsFlat[9*8 +: 8]}, 32'h22);
    chk("R2", "reg7 untouched", {24'b0, regsFlat[7*8 +: 8]}, 32'h00);
    xfer(1'b1, 1, 10, 2, 1, -1, "R2");

    // R3: open-ended write and read
    wrBuf[0] = 8'h01; wrBuf[1] = 8'h82; wrBuf[2] = 8'h43;
    wrBuf[3] = 8'hC4; wrBuf[4] = 8'h25;
    xfer(1'b0, 3, 20, 5, 0, -1, "R3");
    chk("R3", "reg16 fifth byte", {24'b0, regsFlat[16*8 +: 8]}, 32'h25);
    xfer(1'b1, 3, 20, 5, 0, -1, "R3");

    // R4: aborts drop partial bytes
    wrBuf[0] = 8'h77;
    xfer(1'b0, 0, 3, 1, 0, 20, "R4");
    chk("R4", "reg3 after abort", {24'b0, regsFlat[3*8 +: 8]}, 32'h00);
    wrBuf[0] = 8'h5C; wrBuf[1] = 8'h6D;
    xfer(1'b0, 3, 24, 2, 0, 27, "R4");
    chk("R4", "reg24 full byte kept", {24'b0, regsFlat[24*8 +: 8]}, 32'h5C);
    chk("R4", "reg23 partial dropped", {24'b0, regsFlat[23*8 +: 8]}, 32'h00);

    // R11: out of range
    wrBuf[0] = 8'h99;
    xfer(1'b0, 0, 'h100, 1, 0, -1, "R11");
    xfer(1'b1, 0, 'h100, 1, 0, -1, "R11");

    // R9 wrap through register 0 down to the top address
    wrBuf[0] = 8'h42;
    xfer(1'b0, 0, 1, 1, 0, -1, "R8");
    xfer(1'b1, 3, 1, 3, 0, -1, "R9");

    // R10: configuration register
    wrBuf[0] = 8'hF0;
    xfer(1'b0, 0, 0, 1, 0, -1, "R10");
    chk("R10", "upper data ignored", {24'b0, regsFlat[7:0]}, 32'h18);
    wrBuf[0] = 8'h04;
    xfer(1'b0, 0, 0, 1, 0, -1, "R10");
    chk("R10", "spare bit mirrored", {24'b0, regsFlat[7:0]}, 32'h3C);

    // R5: least-significant-first with ascending addresses
    wrBuf[0] = 8'h06;
    xfer(1'b0, 0, 0, 1, 0, -1, "R5");
    chk("R5", "cfg lsb-first", {24'b0, regsFlat[7:0]}, 32'h7E);
    wrBuf[0] = 8'h81; wrBuf[1] = 8'h3C; wrBuf[2] = 8'hE7;
    xfer(1'b0, 3, 12, 3, 0, -1, "R5");
    chk("R9", "reg13 ascending", {24'b0, regsFlat[13*8 +: 8]}, 32'h3C);
    xfer(1'b1, 2, 12, 3, 0, -1, "R5");

    // R7: separate output pin
    wrBuf[0] = 8'h07;
    xfer(1'b0, 0, 0, 1, 0, -1, "R7");
    chk("R7", "cfg sdo mode", {24'b0, regsFlat[7:0]}, 32'hFF);
    xfer(1'b1, 1, 12, 2, 0, -1, "R7");
    xfer(1'b1, 0, 0, 1, 0, -1, "R10");

    // back to defaults, sent least-significant-first
    wrBuf[0] = 8'h00;
    xfer(1'b0, 0, 0, 1, 0, -1, "R5");
    chk("R5", "cfg restored", {24'b0, regsFlat[7:0]}, 32'h18);
    xfer(1'b1, 0, 5, 1, 0, -1, "R6");

    chkOn = 1'b0;
    summary();
    $finish;
  end
endmodule